// File: doc/BRIEF.md
# Three-Process Shared Counter Transfer

This block keeps two wrapping counters, named X and Y, that three guarded processes update. Process 0 adds one to X. Process 1 takes one unit out of X and puts it into Y, changing both counters in the same clock edge. Process 2 takes one from Y. Each process has its own request condition input. In every cycle a scheduler looks at the raised conditions and decides which processes may fire.

Two processes that write a common counter never fire together. When they would, the one with the higher fixed urgency wins: process 2 beats process 1, and process 1 beats process 0. Processes that share no counter are granted together in one cycle. Processes 0 and 2 are such a pair. So when all three conditions are raised, process 1 is the one held back.

The scheduler is written for any number of processes and counters. It reads a write-mask parameter and claims counters in urgency order. Each counter lane applies its own increment and decrement grants. The grants of each cycle are registered as fired flags, so that they line up with the counter values they produced.

Top module: `ctr_transfer_top`

## Requirements
- R1: While rst_n is low, and after its release until the first grant, x_o, y_o and fired_o are all zero.
- R2: Process 0 alone (cond_i = 3'b001) raises x_o by one and leaves y_o unchanged. fired_o is 3'b001 after that edge. Bit i of cond_i and fired_o belongs to process i.
- R3: Process 1 alone (cond_i = 3'b010) lowers x_o by one and raises y_o by one on the same edge. fired_o is 3'b010.
- R4: Process 2 is granted whenever its condition is raised. Alone (3'b100) it lowers y_o by one and leaves x_o unchanged.
- R5: With cond_i = 3'b111, processes 2 and 0 fire (fired_o = 3'b101). x_o rises by one, y_o falls by one, and process 1 is blocked.
- R6: With cond_i = 3'b011, process 1 fires and process 0 is blocked (fired_o = 3'b010). Processes 0 and 1 never fire in the same cycle.
- R7: With cond_i = 3'b110, process 2 fires and process 1 is blocked (fired_o = 3'b100). Processes 1 and 2 never fire in the same cycle.
- R8: With cond_i = 3'b101, processes 0 and 2 both fire in one cycle.
- R9: Both counters are WIDTH bits wide (default 8) and wrap modulo 2^WIDTH. With the default width, 255 plus one gives 0 and 0 minus one gives 255.
- R10: A process whose condition is low is never granted, and fired_o always matches the urgency-ordered grant of the previous cycle's conditions.
- R11: With cond_i = 3'b000, both counters hold their values and fired_o returns to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_i | input | 3 | Request condition; bit i for process i |
| x_o | output | WIDTH | Counter X |
| y_o | output | WIDTH | Counter Y |
| fired_o | output | 3 | Registered grants; bit i set when process i fired on the last edge |

## Verification
The assertions check on every cycle the properties that hold for any input. The conflicting pairs (0 with 1, and 1 with 2) never fire together. No grant is given without its condition. Process 2 is always granted when it asks. Idle cycles leave both counters unchanged. When process 0 fires without process 1, X rises by exactly one.

The bench scenarios show the rest. These are the exact grant chosen for each combination of conditions, the net change to both counters when two processes fire together, and the wrap at both ends of each counter. For these, a reference model computes the expected values, which are compared in a scoreboard, including over a long pseudo-random run of conditions.

// File: rtl/ctr_sched_pkg.sv
package ctr_sched_pkg;

    localparam int NPROC = 3;
    localparam int NRES  = 2;

    localparam int RES_X = 0;
    localparam int RES_Y = 1;

    localparam int P_INC_X  = 0;
    localparam int P_MOVE   = 1;
    localparam int P_DEC_Y  = 2;

    // Write mask, flattened as [proc*NRES + res]. A higher process index is more urgent.
    localparam logic [NPROC*NRES-1:0] WRITE_MASK = {
        2'b10,  // process 2 writes Y
        2'b11,  // process 1 writes X and Y
        2'b01   // process 0 writes X
    };

    typedef enum logic [1:0] {
        LANE_HOLD = 2'd0,
        LANE_INC  = 2'd1,
        LANE_DEC  = 2'd2,
        LANE_BOTH = 2'd3
    } lane_op_e;

endpackage

// File: rtl/ctr_grant_sched.sv
module ctr_grant_sched #(
    parameter int                      N_PROC = 3,
    parameter int                      N_RES  = 2,
    parameter logic [N_PROC*N_RES-1:0] WMASK  = '0
) (
    input  logic [N_PROC-1:0] req_i,
    output logic [N_PROC-1:0] gnt_o
);

    logic [N_RES-1:0] claimed;

    // Walk from the most urgent process down, claiming written resources.
    always_comb begin
        claimed = '0;
        gnt_o   = '0;
        for (int p = N_PROC - 1; p >= 0; p--) begin
            if (req_i[p] && ((claimed & WMASK[p*N_RES +: N_RES]) == '0)) begin
                gnt_o[p] = 1'b1;
                claimed  = claimed | WMASK[p*N_RES +: N_RES];
            end
        end
    end

endmodule

// File: rtl/ctr_lane.sv
module ctr_lane
    import ctr_sched_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [WIDTH-1:0] val_o
);

    lane_op_e         op;
    logic [WIDTH-1:0] val_q;
    logic [WIDTH-1:0] val_d;

    always_comb begin
        op = lane_op_e'({dec_i, inc_i});
    end

    always_comb begin
        unique case (op)
            LANE_INC:  val_d = val_q + WIDTH'(1);
            LANE_DEC:  val_d = val_q - WIDTH'(1);
            LANE_BOTH: val_d = val_q;
            default:   val_d = val_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign val_o = val_q;

endmodule

// File: rtl/ctr_transfer_top.sv
module ctr_transfer_top
    import ctr_sched_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cond_i,
    output logic [WIDTH-1:0] x_o,
    output logic [WIDTH-1:0] y_o,
    output logic [2:0]       fired_o
);

    logic [NPROC-1:0] gnt;
    logic [NPROC-1:0] fired_q;
    logic [NRES-1:0]  res_inc;
    logic [NRES-1:0]  res_dec;
    logic [WIDTH-1:0] res_val [NRES];

    ctr_grant_sched #(
        .N_PROC (NPROC),
        .N_RES  (NRES),
        .WMASK  (WRITE_MASK)
    ) u_sched (
        .req_i (cond_i),
        .gnt_o (gnt)
    );

    assign res_inc[RES_X] = gnt[P_INC_X];
    assign res_dec[RES_X] = gnt[P_MOVE];
    assign res_inc[RES_Y] = gnt[P_MOVE];
    assign res_dec[RES_Y] = gnt[P_DEC_Y];

    for (genvar r = 0; r < NRES; r++) begin : g_lane
        ctr_lane #(.WIDTH(WIDTH)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (res_inc[r]),
            .dec_i (res_dec[r]),
            .val_o (res_val[r])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fired_q <= '0;
        end else begin
            fired_q <= gnt;
        end
    end

    assign x_o     = res_val[RES_X];
    assign y_o     = res_val[RES_Y];
    assign fired_o = fired_q;

endmodule

// File: rtl/ctr_transfer_chk.sv
module ctr_transfer_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cond_i,
    input logic [WIDTH-1:0] x_o,
    input logic [WIDTH-1:0] y_o,
    input logic [2:0]       fired_o
);

    AST_NO_X_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        !(fired_o[0] && fired_o[1])); // R6

    AST_NO_Y_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        !(fired_o[1] && fired_o[2])); // R7

    AST_P0_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_i[0] |=> !fired_o[0]); // R10

    AST_P1_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_i[1] |=> !fired_o[1]); // R10

    AST_P2_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_i[2] |=> !fired_o[2]); // R10

    AST_P2_ALWAYS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cond_i[2] |=> fired_o[2]); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 3'b000) |=> ($stable(x_o) && $stable(y_o) && fired_o == 3'b000)); // R11

    AST_X_INC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 3'b001) |=> (x_o == WIDTH'($past(x_o) + WIDTH'(1)))); // R2

endmodule

bind ctr_transfer_top ctr_transfer_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cond_i  (cond_i),
    .x_o     (x_o),
    .y_o     (y_o),
    .fired_o (fired_o)
);

// File: tb/sim_ctr_transfer_top.sv
module sim_ctr_transfer_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;

    typedef struct {
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic [2:0]   f;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   cond = 3'b000;
    logic [W-1:0] x_o, y_o;
    logic [2:0]   fired_o;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    logic [W-1:0] mx = '0;
    logic [W-1:0] my = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctr_transfer_top #(.WIDTH(W)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond_i  (cond),
        .x_o     (x_o),
        .y_o     (y_o),
        .fired_o (fired_o)
    );

    // Driver: apply a condition set and push the reference result.
    task automatic drive(input logic [2:0] c, input string tag);
        logic g0, g1, g2;
        exp_t e;
        @(negedge clk);
        cond = c;
        g2 = c[2];
        g1 = c[1] && !c[2];
        g0 = c[0] && !g1;
        if (g0) mx = mx + 8'd1;
        if (g1) begin mx = mx - 8'd1; my = my + 8'd1; end
        if (g2) my = my - 8'd1;
        e.x = mx; e.y = my; e.f = {g2, g1, g0}; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare after every edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_run++;
                if (x_o !== e.x || y_o !== e.y || fired_o !== e.f) begin
                    n_fail++;
                    $display("FAIL %s: x=%0d y=%0d fired=%b, expected x=%0d y=%0d fired=%b",
                             e.tag, x_o, y_o, fired_o, e.x, e.y, e.f);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        repeat (3) @(negedge clk);
        n_run++;
        if (x_o !== 8'd0 || y_o !== 8'd0 || fired_o !== 3'b000) begin
            n_fail++;
            $display("FAIL R1: x=%0d y=%0d fired=%b, expected 0 0 000", x_o, y_o, fired_o);
        end
        rst_n = 1'b1;

        drive(3'b000, "R11 idle");
        drive(3'b001, "R2 p0");
        drive(3'b001, "R2 p0");
        drive(3'b001, "R2 p0");
        drive(3'b010, "R3 p1");
        drive(3'b100, "R4 p2");
        drive(3'b100, "R9 y underflow");
        drive(3'b101, "R8 p0+p2");
        drive(3'b111, "R5 all");
        drive(3'b011, "R6 p0+p1");
        drive(3'b110, "R7 p1+p2");
        drive(3'b000, "R11 hold");
        drive(3'b010, "R3 p1");

        lfsr = 8'hA5;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            drive(lfsr[2:0], "R10 random");
        end

        while (mx != 8'd0) drive(3'b010, "R3 drain x");
        drive(3'b010, "R9 x underflow");
        drive(3'b001, "R9 x overflow");
        while (my != 8'd255) drive(3'b010, "R3 fill y");
        drive(3'b010, "R9 y overflow");

        drive(3'b000, "R11 idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule